// File: doc/BRIEF.md
# Single-Error-Correcting Parity Codec for 16-bit Words

This block protects a 16-bit word held in memory with five parity bits. It has two independent halves that share no state. The encode half takes the word that is about to be stored and returns its five check bits. The correct half takes a word and check bits that were read back. It recomputes the parity, forms a five-bit syndrome and repairs any single flipped bit before the word leaves the block.

The word and its check bits together form a 21-bit codeword. Positions are numbered from 1 upwards. The check bits occupy the power-of-two positions. The data bits fill the other positions in ascending order. With this layout a nonzero syndrome is the position number of the bit that flipped. The block holds no state and has no clock and no reset. Both halves settle in the same evaluation, so a memory controller can encode a write and repair a read at the same moment.

Top module: `hsec_codec`

## Requirements
- R1: `enc_check_o[k]` equals the XOR of every data bit whose codeword position number has bit k set, for k = 0 to 4.
- R2: Check bit k sits at position 2^k, giving positions 1, 2, 4, 8 and 16. Data bit 0 sits at position 3. Bits 1 to 3 sit at positions 5 to 7. Bits 4 to 10 sit at positions 9 to 15. Bits 11 to 15 sit at positions 17 to 21.
- R3: `fix_syndrome_o` is the parity recomputed from `fix_data_i`, XORed with `fix_check_i`. When the syndrome is zero, `fix_data_o` equals `fix_data_i` and both flags are low.
- R4: When the syndrome equals the position of a data bit, `fix_data_o` is `fix_data_i` with that one bit inverted, and `fix_fixed_o` is high.
- R5: When the syndrome equals a check-bit position (1, 2, 4, 8 or 16), `fix_data_o` equals `fix_data_i` and `fix_fixed_o` is still high.
- R6: When the syndrome is between 22 and 31, `fix_fatal_o` is high, `fix_fixed_o` is low and `fix_data_o` equals `fix_data_i`.
- R7: `fix_fixed_o` and `fix_fatal_o` are never high together. All outputs follow the inputs combinationally, with no clock.
- R8: The encode and correct halves are independent. Driving both halves with unrelated values at the same time gives each half its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 16 | Word to be stored |
| enc_check_o | output | 5 | Check bits for enc_data_i |
| fix_data_i | input | 16 | Word read back from storage |
| fix_check_i | input | 5 | Check bits read back from storage |
| fix_syndrome_o | output | 5 | Recomputed parity XOR stored parity |
| fix_data_o | output | 16 | Word after single-bit repair |
| fix_fixed_o | output | 1 | Syndrome named a valid position |
| fix_fatal_o | output | 1 | Syndrome is beyond the codeword length |

## Verification
Two things happen in the same evaluation: encoding a new word and repairing a different read-back word. Every vector drives both halves with unrelated data, and both results are judged in the same sample. Read-back codewords are built by the bench from clean encodings. The bench injects no flip, each single flip at all 21 positions, and every pair of flips. Pairs of flips can alias to a data position, to a check position or past the codeword end. A reference that XORs the position numbers of the set codeword bits supplies the expected syndrome, data and flag for each of these cases.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  localparam int DATA_W = 16;

  // Smallest number of check bits r with 2^r >= data bits + r + 1.
  function automatic int chk_width(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position (1-based) of data bit idx: the idx-th non power of two.
  function automatic int data_pos(input int idx);
    int cnt;
    cnt = 0;
    for (int p = 3; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/hsec_parity_gen.sv
// XOR tree: check bit k covers every data bit whose position has bit k set.
module hsec_parity_gen #(
  parameter int DW = hsec_pkg::DATA_W,
  localparam int CW = hsec_pkg::chk_width(DW)
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);

  for (genvar k = 0; k < CW; k++) begin : g_chk
    logic [DW-1:0] covered;
    for (genvar i = 0; i < DW; i++) begin : g_bit
      localparam int POS = hsec_pkg::data_pos(i);
      localparam bit TAKE = ((POS >> k) & 1) != 0;
      if (TAKE) begin : g_on
        assign covered[i] = data_i[i];
      end else begin : g_off
        assign covered[i] = 1'b0;
      end
    end
    assign check_o[k] = ^covered;
  end

endmodule

// File: rtl/hsec_repair.sv
// Turns a syndrome into a single-bit flip mask and the two status flags.
module hsec_repair #(
  parameter int DW = hsec_pkg::DATA_W,
  localparam int CW = hsec_pkg::chk_width(DW),
  localparam int CODE_LEN = DW + CW
) (
  input  logic [CW-1:0] syndrome_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          fixed_o,
  output logic          fatal_o
);

  logic [DW-1:0] flip;
  logic          nonzero;
  logic          in_range;

  for (genvar i = 0; i < DW; i++) begin : g_flip
    localparam int POS = hsec_pkg::data_pos(i);
    assign flip[i] = (syndrome_i == CW'(POS));
  end

  assign nonzero  = |syndrome_i;
  assign in_range = int'(syndrome_i) <= CODE_LEN;
  assign fixed_o  = nonzero && in_range;
  assign fatal_o  = !in_range;
  assign data_o   = data_i ^ flip;

endmodule

// File: rtl/hsec_codec.sv
// Encode half and correct half side by side; no clock, no state.
module hsec_codec #(
  parameter int DW = hsec_pkg::DATA_W,
  localparam int CW = hsec_pkg::chk_width(DW)
) (
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_check_o,
  input  logic [DW-1:0] fix_data_i,
  input  logic [CW-1:0] fix_check_i,
  output logic [CW-1:0] fix_syndrome_o,
  output logic [DW-1:0] fix_data_o,
  output logic          fix_fixed_o,
  output logic          fix_fatal_o
);

  logic [CW-1:0] recomputed;

  hsec_parity_gen #(.DW(DW)) u_enc_par (
    .data_i (enc_data_i),
    .check_o(enc_check_o)
  );

  hsec_parity_gen #(.DW(DW)) u_fix_par (
    .data_i (fix_data_i),
    .check_o(recomputed)
  );

  assign fix_syndrome_o = recomputed ^ fix_check_i;

  hsec_repair #(.DW(DW)) u_repair (
    .syndrome_i(fix_syndrome_o),
    .data_i    (fix_data_i),
    .data_o    (fix_data_o),
    .fixed_o   (fix_fixed_o),
    .fatal_o   (fix_fatal_o)
  );

endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk #(
  parameter int DW = hsec_pkg::DATA_W,
  localparam int CW = hsec_pkg::chk_width(DW)
) (
  input logic [DW-1:0] enc_data_i,
  input logic [CW-1:0] enc_check_o,
  input logic [DW-1:0] fix_data_i,
  input logic [CW-1:0] fix_check_i,
  input logic [CW-1:0] fix_syndrome_o,
  input logic [DW-1:0] fix_data_o,
  input logic          fix_fixed_o,
  input logic          fix_fatal_o
);

  logic known;
  assign known = !$isunknown({enc_data_i, fix_data_i, fix_check_i});

  always_comb begin
    if (known) begin
      // R1: a word that matches the encoder's own output reads back clean
      assert_roundtrip_clean_R1: assert (!((fix_data_i == enc_data_i) &&
          (fix_check_i == enc_check_o)) || (fix_syndrome_o == '0))
        else $error("roundtrip syndrome not zero");
      assert_clean_passthru_R3: assert ((fix_syndrome_o != '0) ||
          ((fix_data_o == fix_data_i) && !fix_fixed_o && !fix_fatal_o))
        else $error("clean word altered or flagged");
      assert_single_flip_R4: assert (!fix_fixed_o ||
          ($countones(fix_data_o ^ fix_data_i) <= 1))
        else $error("more than one bit changed");
      assert_check_pos_keeps_R5: assert (!(fix_fixed_o &&
          ($countones(fix_syndrome_o) == 1)) || (fix_data_o == fix_data_i))
        else $error("check-bit error altered data");
      assert_fatal_passthru_R6: assert (!fix_fatal_o || (fix_data_o == fix_data_i))
        else $error("fatal word altered");
      assert_flags_exclusive_R7: assert (!(fix_fixed_o && fix_fatal_o))
        else $error("both flags high");
    end
  end

endmodule

bind hsec_codec hsec_codec_chk #(.DW(DW)) u_chk (
  .enc_data_i    (enc_data_i),
  .enc_check_o   (enc_check_o),
  .fix_data_i    (fix_data_i),
  .fix_check_i   (fix_check_i),
  .fix_syndrome_o(fix_syndrome_o),
  .fix_data_o    (fix_data_o),
  .fix_fixed_o   (fix_fixed_o),
  .fix_fatal_o   (fix_fatal_o)
);

// File: tb/hsec_codec_bench.sv
module hsec_codec_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] enc_data_i = '0;
  logic [4:0]  enc_check_o;
  logic [15:0] fix_data_i = '0;
  logic [4:0]  fix_check_i = '0;
  logic [4:0]  fix_syndrome_o;
  logic [15:0] fix_data_o;
  logic        fix_fixed_o;
  logic        fix_fatal_o;

  hsec_codec u_hsec_codec (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int data_at[32];   // position -> data bit index, -1 for check/unused
  int chk_at[32];    // position -> check bit index, -1 otherwise

  initial begin
    int n;
    n = 0;
    for (int p = 0; p < 32; p++) begin
      data_at[p] = -1;
      chk_at[p]  = -1;
    end
    for (int p = 1; p <= 21; p++) begin
      if ((p & (p - 1)) == 0) begin
        for (int k = 0; k < 5; k++) if ((1 << k) == p) chk_at[p] = k;
      end else begin
        data_at[p] = n;
        n++;
      end
    end
  end

  function automatic logic [4:0] ref_enc(input logic [15:0] d);
    logic [4:0] c;
    c = '0;
    for (int k = 0; k < 5; k++)
      for (int p = 1; p <= 21; p++)
        if (data_at[p] >= 0 && ((p >> k) & 1) == 1) c[k] ^= d[data_at[p]];
    return c;
  endfunction

  function automatic int ref_syn(input logic [15:0] d, input logic [4:0] c);
    int s;
    bit b;
    s = 0;
    for (int p = 1; p <= 21; p++) begin
      b = (data_at[p] >= 0) ? d[data_at[p]] : c[chk_at[p]];
      if (b) s ^= p;
    end
    return s;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ed, input logic [15:0] fd, input logic [4:0] fc,
                       input string enc_tag);
    int s;
    logic [15:0] exp_d;
    string tag;
    @(posedge clk);
    #1;
    enc_data_i  = ed;
    fix_data_i  = fd;
    fix_check_i = fc;
    @(negedge clk);
    s = ref_syn(fd, fc);
    exp_d = fd;
    if (s == 0) tag = "R3";
    else if (s > 21) tag = "R6";
    else if (chk_at[s] >= 0) tag = "R5";
    else begin
      tag = "R4";
      exp_d[data_at[s]] = ~exp_d[data_at[s]];
    end
    check(enc_tag, "enc_check", int'(enc_check_o), int'(ref_enc(ed)));
    check("R3", "syndrome", int'(fix_syndrome_o), s);
    check(tag, "data", int'(fix_data_o), int'(exp_d));
    check(tag, "fixed", int'(fix_fixed_o), (s != 0 && s <= 21) ? 1 : 0);
    check(tag, "fatal", int'(fix_fatal_o), (s > 21) ? 1 : 0);
    check("R7", "flag_pair", int'(fix_fixed_o & fix_fatal_o), 0);
  endtask

  // Flip codeword positions given by mask bits 1..21, then apply.
  task automatic inject(input logic [15:0] ed, input logic [15:0] d, input int mask);
    logic [15:0] fd;
    logic [4:0]  fc;
    fd = d;
    fc = ref_enc(d);
    for (int p = 1; p <= 21; p++) begin
      if (((mask >> p) & 1) == 1) begin
        if (data_at[p] >= 0) fd[data_at[p]] = ~fd[data_at[p]];
        else fc[chk_at[p]] = ~fc[chk_at[p]];
      end
    end
    apply(ed, fd, fc, "R8");
  endtask

  initial begin
    logic [15:0] words [4];
    words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'hA5C3; words[3] = 16'h1234;
    #2;
    check("R3", "idle_syndrome", int'(fix_syndrome_o), 0);
    // R2/R1: one-hot words expose each bit's position in the check bits
    for (int i = 0; i < 16; i++) apply(16'(1 << i), '0, '0, "R2");
    // R3: clean read-back words
    for (int w = 0; w < 4; w++) inject(~words[w], words[w], 0);
    // R4/R5: every single flip
    for (int w = 0; w < 4; w++)
      for (int p = 1; p <= 21; p++) inject(words[(w + 1) % 4], words[w], 1 << p);
    // R6 and aliases: every pair of flips
    for (int w = 2; w < 4; w++)
      for (int p = 1; p <= 21; p++)
        for (int q = p + 1; q <= 21; q++) inject(words[w] ^ 16'h00FF, words[w], (1 << p) | (1 << q));
    // R8: unrelated random traffic on both halves
    for (int r = 0; r < 300; r++)
      apply(16'($urandom), 16'($urandom), 5'($urandom), "R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule